// File: doc/BRIEF.md
# Decimal Adjust Unit

This unit repairs the 8-bit result of a binary addition so that it reads as decimal digits again. A caller presents the low result byte, the high byte, the half-carry and carry flags left by the addition, and a mode select, then pulses a strobe. One cycle later the corrected bytes and flags appear on registered outputs.

Two modes exist. Packed mode treats the low byte as two BCD digits and adds 6 to either digit or both, and it reports zero, sign and parity of the corrected byte. Unpacked mode treats the low byte as one ASCII or unpacked digit. When that digit overflows, it carries into the high byte, and it always clears the upper nibble of the low byte. Adjustments after subtraction, multiplication and division are not part of this unit.

Top module: `dadj_unit`

## Requirements
- R1: When `valid_i` is high at a clock edge, all result outputs and `valid_o` (high) take new values at that edge. When `valid_i` is low, `valid_o` goes low and every result output keeps its previous value.
- R2: After synchronous reset, every output is 0.
- R3: Packed mode (`mode_i`=0) adds 6 to the low byte when its low nibble exceeds 9 or `af_i` is 1. `af_o` is 1 exactly when this low correction fires.
- R4: Packed mode applies an upper correction when any of these holds: `cf_i` is 1, the low-corrected value carried out of 8 bits, or the low-corrected value exceeds 0x9F. The upper correction adds 0x60 modulo 256 to the low-corrected value to form `al_o`. `cf_o` is 1 exactly when the upper correction fires. Example: AL=0x32 with AF=1 and CF=1 gives 0x98 with CF=1.
- R5: In packed mode, `ah_o` equals `ah_i`.
- R6: In packed mode, `zf_o` is 1 when `al_o` is 0, `sf_o` equals bit 7 of `al_o`, and `pf_o` is 1 when `al_o` holds an even number of ones.
- R7: Unpacked mode (`mode_i`=1) adjusts when the low nibble of AL exceeds 9 or `af_i` is 1. An adjust sets `al_o` to ((AL+6) mod 16), `ah_o` to (AH+1) mod 256, and sets both `af_o` and `cf_o` to 1. Example: AH=0x00 with AL=0x0E gives AH=0x01 and AL=0x04.
- R8: Unpacked mode without an adjust sets `al_o` to AL with its upper nibble cleared, passes AH through unchanged, and sets `af_o` and `cf_o` to 0.
- R9: In unpacked mode, `zf_o`, `sf_o` and `pf_o` are 0, and bits 7:4 of `al_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Strobe: operands are present |
| mode_i | input | 1 | 0 = packed BCD, 1 = unpacked digit |
| al_i | input | 8 | Low result byte of the addition |
| ah_i | input | 8 | High byte |
| af_i | input | 1 | Half-carry flag from the addition |
| cf_i | input | 1 | Carry flag from the addition |
| valid_o | output | 1 | Result is fresh this cycle |
| al_o | output | 8 | Corrected low byte |
| ah_o | output | 8 | Corrected high byte |
| af_o | output | 1 | Half-carry out |
| cf_o | output | 1 | Carry out |
| zf_o | output | 1 | Zero flag (packed mode) |
| sf_o | output | 1 | Sign flag (packed mode) |
| pf_o | output | 1 | Even-parity flag (packed mode) |

## Verification
The case that needs most care is a packed strobe where the low-digit and upper-digit corrections both fire in one cycle. When that happens, the upper test must see the value already raised by 6, including any wrap past 0xFF. The bench reaches this case by sweeping every AL value against all four flag combinations in both modes. It also runs directed strobes for 0x32 with both flags set, for 0x9A, and for 0xFA. Each result is compared against a model written with integer arithmetic. In unpacked mode the sweep sets AH to 0xFF so that the carry into a full high byte is checked for wrap to 0x00 in the same cycle as the nibble fix.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

    localparam int BYTE_W  = 8;
    localparam int DIGIT_W = 4;

    typedef enum logic {
        ADJ_PACKED   = 1'b0,
        ADJ_UNPACKED = 1'b1
    } adj_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] lo_byte;
        logic [BYTE_W-1:0] hi_byte;
        logic              half_c;
        logic              full_c;
    } adj_word_t;

    typedef struct packed {
        logic zero;
        logic sign;
        logic par_even;
    } adj_flags_t;

    function automatic logic digit_over9(input logic [DIGIT_W-1:0] d);
        return d > DIGIT_W'(9);
    endfunction

    function automatic logic even_ones(input logic [BYTE_W-1:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/dadj_packed.sv
module dadj_packed
    import dadj_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] al,
    input  logic         af,
    input  logic         cf,
    output logic [W-1:0] al_fix,
    output logic         af_fix,
    output logic         cf_fix
);
    localparam int NIB_W = W / 2;
    localparam logic [W:0]   LO_ADD   = (W+1)'(6);
    localparam logic [W-1:0] HI_ADD   = W'(6) << NIB_W;
    localparam logic [W-1:0] HI_LIMIT = (W'(9) << NIB_W) | W'((1 << NIB_W) - 1);

    logic         lo_fire;
    logic         hi_fire;
    logic [W:0]   stage1;
    logic [W-1:0] stage1_b;

    always_comb begin
        lo_fire  = digit_over9(al[NIB_W-1:0]) | af;
        stage1   = {1'b0, al} + (lo_fire ? LO_ADD : '0);
        stage1_b = stage1[W-1:0];
        hi_fire  = cf | stage1[W] | (stage1_b > HI_LIMIT);
        al_fix   = stage1_b + (hi_fire ? HI_ADD : '0);
        af_fix   = lo_fire;
        cf_fix   = hi_fire;
    end

endmodule

// File: rtl/dadj_unpacked.sv
module dadj_unpacked
    import dadj_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] al,
    input  logic [W-1:0] ah,
    input  logic         af,
    output logic [W-1:0] al_fix,
    output logic [W-1:0] ah_fix,
    output logic         af_fix,
    output logic         cf_fix
);
    localparam int NIB_W = W / 2;

    logic         fire;
    logic [W-1:0] sum;

    always_comb begin
        fire   = digit_over9(al[NIB_W-1:0]) | af;
        sum    = al + (fire ? W'(6) : '0);
        al_fix = {{(W-NIB_W){1'b0}}, sum[NIB_W-1:0]};
        ah_fix = ah + W'(fire);
        af_fix = fire;
        cf_fix = fire;
    end

endmodule

// File: rtl/dadj_status.sv
module dadj_status
    import dadj_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         en,
    input  logic [W-1:0] value,
    output adj_flags_t   flags
);
    always_comb begin
        flags.zero     = en & (value == '0);
        flags.sign     = en & value[W-1];
        flags.par_even = en & even_ones(value);
    end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
    import dadj_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic         mode_i,
    input  logic [W-1:0] al_i,
    input  logic [W-1:0] ah_i,
    input  logic         af_i,
    input  logic         cf_i,
    output logic         valid_o,
    output logic [W-1:0] al_o,
    output logic [W-1:0] ah_o,
    output logic         af_o,
    output logic         cf_o,
    output logic         zf_o,
    output logic         sf_o,
    output logic         pf_o
);
    adj_mode_e mode;
    assign mode = adj_mode_e'(mode_i);

    logic [W-1:0] p_al;
    logic         p_af, p_cf;
    logic [W-1:0] u_al, u_ah;
    logic         u_af, u_cf;

    dadj_packed #(.W(W)) u_packed (
        .al(al_i), .af(af_i), .cf(cf_i),
        .al_fix(p_al), .af_fix(p_af), .cf_fix(p_cf)
    );

    dadj_unpacked #(.W(W)) u_unpacked (
        .al(al_i), .ah(ah_i), .af(af_i),
        .al_fix(u_al), .ah_fix(u_ah), .af_fix(u_af), .cf_fix(u_cf)
    );

    adj_word_t  nxt_word, cur_word;
    adj_flags_t nxt_flags, cur_flags;

    always_comb begin
        if (mode == ADJ_PACKED) begin
            nxt_word.lo_byte = p_al;
            nxt_word.hi_byte = ah_i;
            nxt_word.half_c  = p_af;
            nxt_word.full_c  = p_cf;
        end else begin
            nxt_word.lo_byte = u_al;
            nxt_word.hi_byte = u_ah;
            nxt_word.half_c  = u_af;
            nxt_word.full_c  = u_cf;
        end
    end

    dadj_status #(.W(W)) u_status (
        .en(mode == ADJ_PACKED), .value(p_al), .flags(nxt_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            cur_word  <= '0;
            cur_flags <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                cur_word  <= nxt_word;
                cur_flags <= nxt_flags;
            end
        end
    end

    assign al_o = cur_word.lo_byte;
    assign ah_o = cur_word.hi_byte;
    assign af_o = cur_word.half_c;
    assign cf_o = cur_word.full_c;
    assign zf_o = cur_flags.zero;
    assign sf_o = cur_flags.sign;
    assign pf_o = cur_flags.par_even;

endmodule

// File: rtl/dadj_checks.sv
module dadj_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         valid_i,
    input logic         mode_i,
    input logic [W-1:0] ah_i,
    input logic         cf_i,
    input logic         valid_o,
    input logic [W-1:0] al_o,
    input logic [W-1:0] ah_o,
    input logic         af_o,
    input logic         cf_o,
    input logic         zf_o,
    input logic         sf_o,
    input logic         pf_o
);
    // R1
    strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    // R1
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable({al_o, ah_o, af_o, cf_o, zf_o, sf_o, pf_o}));
    // R4
    carry_in_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !mode_i && cf_i) |=> cf_o);
    // R5
    packed_ah_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !mode_i) |=> ah_o == $past(ah_i));
    // R6
    packed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !mode_i) |=> (zf_o == (al_o == '0)) && (sf_o == al_o[W-1]));
    // R7
    unpacked_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i) |=> af_o == cf_o);
    // R9
    unpacked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mode_i) |=> !zf_o && !sf_o && !pf_o && (al_o[W-1:W/2] == '0));
endmodule

bind dadj_unit dadj_checks #(.W(W)) u_checks (
    .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
    .ah_i(ah_i), .cf_i(cf_i), .valid_o(valid_o), .al_o(al_o),
    .ah_o(ah_o), .af_o(af_o), .cf_o(cf_o), .zf_o(zf_o),
    .sf_o(sf_o), .pf_o(pf_o)
);

// File: tb/dadj_unit_test.sv
`timescale 1ns/1ps
module dadj_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [7:0] al_i = '0, ah_i = '0;
    logic       af_i = 1'b0, cf_i = 1'b0;
    logic       valid_o;
    logic [7:0] al_o, ah_o;
    logic       af_o, cf_o, zf_o, sf_o, pf_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    dadj_unit uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
        .al_i(al_i), .ah_i(ah_i), .af_i(af_i), .cf_i(cf_i),
        .valid_o(valid_o), .al_o(al_o), .ah_o(ah_o), .af_o(af_o),
        .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // Apply one strobe and compare against the arithmetic model
    task automatic run_one(input int m, input int al, input int ah, input int af, input int cf);
        int t, lo, fl, fh, eal, eah, eaf, ecf, ez, es, ep;
        @(negedge clk);
        valid_i = 1'b1; mode_i = m[0]; al_i = al[7:0]; ah_i = ah[7:0];
        af_i = af[0]; cf_i = cf[0];
        @(negedge clk);
        valid_i = 1'b0;
        lo = al % 16;
        fl = (lo > 9 || af != 0) ? 1 : 0;
        if (m == 0) begin
            t   = al + (fl ? 6 : 0);
            fh  = (cf != 0 || t > 255 || (t % 256) > 159) ? 1 : 0;
            eal = ((t % 256) + (fh ? 96 : 0)) % 256;
            eah = ah; eaf = fl; ecf = fh;
            ez  = (eal == 0) ? 1 : 0;
            es  = eal / 128;
            ep  = (ones(eal) % 2 == 0) ? 1 : 0;
            check(valid_o == 1'b1, "R1 valid", valid_o, 1);
            check(af_o == eaf[0], "R3 half-carry", af_o, eaf);
            check(al_o == eal[7:0] && cf_o == ecf[0], "R4 al/carry", {al_o, 3'b0, cf_o}, eal * 16 + ecf);
            check(ah_o == eah[7:0], "R5 ah pass", ah_o, eah);
            check({zf_o, sf_o, pf_o} == {ez[0], es[0], ep[0]}, "R6 z/s/p", {zf_o, sf_o, pf_o}, ez * 4 + es * 2 + ep);
        end else begin
            eal = (al + (fl ? 6 : 0)) % 16;
            eah = (ah + fl) % 256;
            if (fl != 0)
                check(al_o == eal[7:0] && ah_o == eah[7:0] && af_o && cf_o, "R7 adjust",
                      {ah_o, al_o, af_o, cf_o}, (eah * 256 + eal) * 4 + 3);
            else
                check(al_o == eal[7:0] && ah_o == eah[7:0] && !af_o && !cf_o, "R8 no adjust",
                      {ah_o, al_o, af_o, cf_o}, (eah * 256 + eal) * 4);
            check({zf_o, sf_o, pf_o} == 3'b000, "R9 flags clear", {zf_o, sf_o, pf_o}, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check({valid_o, al_o, ah_o, af_o, cf_o, zf_o, sf_o, pf_o} == '0, "R2 reset",
              {valid_o, al_o, ah_o, af_o, cf_o, zf_o, sf_o, pf_o}, 0);
        rst = 1'b0;

        // Directed corner cases: both corrections in one cycle, wrap, carry into AH
        run_one(0, 8'h32, 8'h00, 1, 1);
        check(al_o == 8'h98 && cf_o, "R4 0x32 example", al_o, 8'h98);
        run_one(0, 8'h9A, 8'h11, 0, 0);
        run_one(0, 8'hFA, 8'h22, 0, 0);
        run_one(1, 8'h0E, 8'h00, 0, 0);
        check(al_o == 8'h04 && ah_o == 8'h01, "R7 0x0E example", {ah_o, al_o}, 16'h0104);
        run_one(1, 8'h3F, 8'hFF, 0, 0);

        // R1 hold: change inputs without strobe, outputs must stay
        begin
            logic [20:0] snap;
            snap = {al_o, ah_o, af_o, cf_o, zf_o, sf_o, pf_o};
            @(negedge clk);
            mode_i = 1'b0; al_i = 8'h77; ah_i = 8'h55; af_i = 1'b1; cf_i = 1'b1;
            @(negedge clk);
            @(negedge clk);
            check(valid_o == 1'b0, "R1 idle valid", valid_o, 0);
            check({al_o, ah_o, af_o, cf_o, zf_o, sf_o, pf_o} == snap, "R1 hold",
                  {al_o, ah_o, af_o, cf_o, zf_o, sf_o, pf_o}, snap);
        end

        // Exhaustive sweep over AL, flags and mode
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 4; f++)
                for (int a = 0; a < 256; a++)
                    run_one(m, a, (m == 1) ? 8'hFF : (a ^ 8'h5A), f & 1, f >> 1);

        // R2 reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check({valid_o, al_o, ah_o, af_o, cf_o} == '0, "R2 re-reset", {al_o, ah_o}, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule